// File: doc/BRIEF.md
# Time-Multiplexed Frame Serializer

This block is the serial output port of a multichannel data converter. Each conversion hands it one set of channel words. It sends them out over `NUM_PINS` serial data lines, paced by a bit clock that is divided down from the core clock. A frame-sync pulse marks the first bit of every frame. Each data line carries 1, 2, 4 or 8 channels, one after another, and every word is either 24 or 40 bits long. The host samples data and frame sync on the rising edge of the bit clock. The block moves them only on the falling edge.

A frame must be fully shifted out before the next conversion arrives. If a new conversion strobe comes while a frame is still being sent, or while earlier data is still waiting to start, the block raises a sticky overrun flag. It then abandons the rest of the old frame and starts the new data at the next falling edge. Changes to the divider, channel count or word width are taken only at frame boundaries.

Top module: `tdm_frame_serializer`

## Requirements
- R1: `bclk` is low for D core cycles and high for D core cycles, where D is `cfg_div`. A value of 0 counts as 1, so the bit period is 2·D core cycles.
- R2: `dout` and `fsync` change only together with a falling edge of `bclk`.
- R3: `fsync` is high for exactly one bit period per frame. It is high in the same bit period as the MSB of the first channel word.
- R4: `cfg_tdm` picks T channels per line (0→1, 1→2, 2→4, 3→8). Line p sends channels p·T to p·T+T-1 in ascending order, each word MSB first. Channel k sits in `chan_data[k*40 +: 40]`. With `cfg_wide`=1 the word is all 40 bits; with `cfg_wide`=0 it is the low 24 bits.
- R5: A frame is exactly T·W bits long on each line, where W is 24 or 40.
- R6: Once the last bit of a frame has gone out, `dout` and `fsync` stay low until the next frame begins.
- R7: A frame is sent only after `conv_strobe`. It begins on the first falling edge of `bclk` that follows the core cycle after the strobe.
- R8: A strobe that arrives while a frame is being sent, or while strobed data has not started yet, sets `overrun`. Once set, `overrun` stays high until reset.
- R9: After an overrun, the newest strobed data starts a complete new frame at the next falling edge of `bclk`, and frame sync is raised for it.
- R10: A change to `cfg_div`, `cfg_tdm` or `cfg_wide` during a frame has no effect on that frame. The new settings apply from the next frame.
- R11: While reset is active, `bclk`, `fsync`, `dout` and `overrun` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core (converter) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_div | input | DIV_W | Bit-clock divide value D (0 treated as 1) |
| cfg_tdm | input | 2 | Channels per line: 0→1, 1→2, 2→4, 3→8 |
| cfg_wide | input | 1 | Word width: 0→24 bits, 1→40 bits |
| conv_strobe | input | 1 | One-cycle conversion strobe; `chan_data` is valid in that cycle |
| chan_data | input | NUM_PINS·8·40 | Channel words, 40-bit slot per channel |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame-sync pulse, one bit period wide |
| dout | output | NUM_PINS | Serial data lines |
| overrun | output | 1 | Sticky lost-data flag |

## Verification
All outputs move in the core cycle that ends a high phase of `bclk`, so the bench samples them at the falling edge of the core clock on each rising edge of `bclk`. That is D core cycles after the data change, with no doubt about which bit it sees. A strobe is first registered and then waits for the next falling edge of `bclk`. The bench therefore expects the frame-sync rising edge between D+1 and 3·D+3 core cycles after the strobe. `overrun` rises one core cycle after the offending strobe and is read on the following falling edge of the core clock. Rule R2 is watched on every core cycle: any change of `dout` between two samples that did not come with a falling edge of `bclk` is counted as a violation.

// File: rtl/tdm_ser_pkg.sv
package tdm_ser_pkg;

  localparam int unsigned SLOT_MAX   = 8;
  localparam int unsigned WORD_MAX   = 40;
  localparam int unsigned WORD_SHORT = 24;
  localparam int unsigned BIT_IDX_W  = $clog2(WORD_MAX);
  localparam int unsigned SLOT_W     = $clog2(SLOT_MAX);

  typedef logic [BIT_IDX_W-1:0] bit_idx_t;
  typedef logic [SLOT_W-1:0]    slot_t;
  typedef logic [SLOT_W:0]      slot_cnt_t;

  typedef enum logic [1:0] {
    TDM_X1 = 2'd0,
    TDM_X2 = 2'd1,
    TDM_X4 = 2'd2,
    TDM_X8 = 2'd3
  } tdm_sel_e;

  function automatic slot_cnt_t slots_of(tdm_sel_e sel);
    return slot_cnt_t'(1) << sel;
  endfunction

  function automatic bit_idx_t msb_of(logic wide);
    return wide ? bit_idx_t'(WORD_MAX - 1) : bit_idx_t'(WORD_SHORT - 1);
  endfunction

endpackage

// File: rtl/tdm_bitclk_gen.sv
module tdm_bitclk_gen #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             bclk,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d, last_cnt;
  logic             bclk_q, bclk_d;
  logic             wrap;

  assign last_cnt = (div_val == '0) ? '0 : div_val - DIV_W'(1);
  assign wrap     = (cnt_q >= last_cnt);

  always_comb begin
    cnt_d  = wrap ? '0 : cnt_q + DIV_W'(1);
    bclk_d = wrap ? ~bclk_q : bclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bclk_q <= bclk_d;
    end
  end

  assign bclk      = bclk_q;
  assign fall_tick = bclk_q & wrap;

  // R1
  bclk_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk_q) |-> (cnt_q == '0));

endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl
  import tdm_ser_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned DIV_W    = 4,
  localparam int unsigned NUM_CH  = NUM_PINS * SLOT_MAX,
  localparam int unsigned DATA_W  = NUM_CH * WORD_MAX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_tick,
  input  logic              conv_strobe,
  input  logic [DIV_W-1:0]  cfg_div,
  input  tdm_sel_e          cfg_tdm,
  input  logic              cfg_wide,
  input  logic [DATA_W-1:0] chan_data,
  output logic [DIV_W-1:0]  div_act,
  output tdm_sel_e          tdm_act,
  output logic [DATA_W-1:0] frame_data,
  output slot_t             slot,
  output bit_idx_t          bit_idx,
  output logic              busy,
  output logic              fsync,
  output logic              overrun
);

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pend_data_q;
  logic [DATA_W-1:0] frame_q;
  logic              busy_q, busy_d;
  logic              fsync_q, fsync_d;
  logic              ovr_q, ovr_d;
  slot_t             slot_q, slot_d;
  bit_idx_t          bit_q, bit_d;
  logic [DIV_W-1:0]  div_q;
  tdm_sel_e          tdm_q;
  logic              wide_q;

  logic start, advance, cfg_load, last_bit, last_slot;

  assign start     = fall_tick & pend_q;
  assign advance   = fall_tick & busy_q & ~pend_q;
  assign cfg_load  = fall_tick & (pend_q | ~busy_q);
  assign last_bit  = (bit_q == '0);
  assign last_slot = ((slot_cnt_t'(slot_q) + slot_cnt_t'(1)) == slots_of(tdm_q));

  always_comb begin
    pend_d  = conv_strobe ? 1'b1 : (start ? 1'b0 : pend_q);
    ovr_d   = ovr_q | (conv_strobe & (busy_q | pend_q));
    busy_d  = busy_q;
    fsync_d = fsync_q;
    slot_d  = slot_q;
    bit_d   = bit_q;
    if (start) begin
      busy_d  = 1'b1;
      fsync_d = 1'b1;
      slot_d  = '0;
      bit_d   = msb_of(cfg_wide);
    end else if (advance) begin
      fsync_d = 1'b0;
      if (!last_bit) begin
        bit_d = bit_q - bit_idx_t'(1);
      end else if (!last_slot) begin
        slot_d = slot_q + slot_t'(1);
        bit_d  = msb_of(wide_q);
      end else begin
        busy_d = 1'b0;
      end
    end else if (fall_tick) begin
      fsync_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      frame_q     <= '0;
      busy_q      <= 1'b0;
      fsync_q     <= 1'b0;
      ovr_q       <= 1'b0;
      slot_q      <= '0;
      bit_q       <= '0;
      div_q       <= '0;
      tdm_q       <= TDM_X1;
      wide_q      <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      ovr_q   <= ovr_d;
      busy_q  <= busy_d;
      fsync_q <= fsync_d;
      slot_q  <= slot_d;
      bit_q   <= bit_d;
      if (conv_strobe) pend_data_q <= chan_data;
      if (start)       frame_q     <= pend_data_q;
      if (cfg_load) begin
        div_q  <= cfg_div;
        tdm_q  <= cfg_tdm;
        wide_q <= cfg_wide;
      end
    end
  end

  assign div_act    = div_q;
  assign tdm_act    = tdm_q;
  assign frame_data = frame_q;
  assign slot       = slot_q;
  assign bit_idx    = bit_q;
  assign busy       = busy_q;
  assign fsync      = fsync_q;
  assign overrun    = ovr_q;

  // R3
  fsync_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_q |-> (busy_q && slot_q == '0 && bit_q == msb_of(wide_q)));

  // R5
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q <= msb_of(wide_q)));

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !pend_q) |=> ($stable(wide_q) && $stable(tdm_q) && $stable(div_q)));

endmodule

// File: rtl/tdm_lane_pick.sv
module tdm_lane_pick
  import tdm_ser_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned PIN    = 0,
  localparam int unsigned DATA_W = NUM_CH * WORD_MAX,
  localparam int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] frame_data,
  input  tdm_sel_e          tdm_sel,
  input  slot_t             slot,
  input  bit_idx_t          bit_idx,
  output logic              bit_out
);

  int unsigned      ch_i;
  int unsigned      pos_i;
  logic [IDX_W-1:0] pos;

  always_comb begin
    ch_i  = PIN * 32'(slots_of(tdm_sel)) + 32'(slot);
    pos_i = ch_i * WORD_MAX + 32'(bit_idx);
    pos   = IDX_W'(pos_i);
    bit_out = (ch_i < NUM_CH) ? frame_data[pos] : 1'b0;
  end

endmodule

// File: rtl/tdm_frame_serializer.sv
module tdm_frame_serializer
  import tdm_ser_pkg::*;
#(
  parameter int unsigned NUM_PINS = 2,
  parameter int unsigned DIV_W    = 4,
  localparam int unsigned NUM_CH  = NUM_PINS * SLOT_MAX,
  localparam int unsigned DATA_W  = NUM_CH * WORD_MAX
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_tdm,
  input  logic                cfg_wide,
  input  logic                conv_strobe,
  input  logic [DATA_W-1:0]   chan_data,
  output logic                bclk,
  output logic                fsync,
  output logic [NUM_PINS-1:0] dout,
  output logic                overrun
);

  logic [1:0] rst_pipe;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign core_rst_n = rst_pipe[1];

  logic              fall_tick;
  logic [DIV_W-1:0]  div_act;
  tdm_sel_e          tdm_act;
  logic [DATA_W-1:0] frame_data;
  slot_t             slot;
  bit_idx_t          bit_idx;
  logic              busy;
  logic [NUM_PINS-1:0] lane_bits;

  tdm_bitclk_gen #(.DIV_W(DIV_W)) u_bitclk (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .div_val   (div_act),
    .bclk      (bclk),
    .fall_tick (fall_tick)
  );

  tdm_frame_ctrl #(.NUM_PINS(NUM_PINS), .DIV_W(DIV_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .fall_tick   (fall_tick),
    .conv_strobe (conv_strobe),
    .cfg_div     (cfg_div),
    .cfg_tdm     (tdm_sel_e'(cfg_tdm)),
    .cfg_wide    (cfg_wide),
    .chan_data   (chan_data),
    .div_act     (div_act),
    .tdm_act     (tdm_act),
    .frame_data  (frame_data),
    .slot        (slot),
    .bit_idx     (bit_idx),
    .busy        (busy),
    .fsync       (fsync),
    .overrun     (overrun)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lane
    tdm_lane_pick #(.NUM_CH(NUM_CH), .PIN(p)) u_pick (
      .frame_data (frame_data),
      .tdm_sel    (tdm_act),
      .slot       (slot),
      .bit_idx    (bit_idx),
      .bit_out    (lane_bits[p])
    );
  end

  assign dout = busy ? lane_bits : '0;

  // R2
  dout_edge_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(dout) |-> $fell(bclk));

  // R3
  fsync_busy_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    fsync |-> busy);

endmodule

// File: tb/tdm_frame_serializer_test.sv
module tdm_frame_serializer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_PINS   = 2;
  localparam int DIV_W      = 4;
  localparam int NUM_CH     = NUM_PINS * 8;
  localparam int DATA_W     = NUM_CH * 40;

  typedef struct packed {
    logic [3:0] div;
    logic [1:0] tdm;
    logic       wide;
    logic [7:0] seed;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'd1, 2'd0, 1'b0, 8'h11},
    '{4'd2, 2'd1, 1'b0, 8'h22},
    '{4'd1, 2'd2, 1'b1, 8'h33},
    '{4'd3, 2'd1, 1'b1, 8'h44},
    '{4'd0, 2'd3, 1'b0, 8'h55},
    '{4'd2, 2'd3, 1'b1, 8'h66}
  };

  logic                clk = 1'b0;
  logic                rst_n;
  logic [DIV_W-1:0]    cfg_div;
  logic [1:0]          cfg_tdm;
  logic                cfg_wide;
  logic                conv_strobe;
  logic [DATA_W-1:0]   chan_data;
  logic                bclk;
  logic                fsync;
  logic [NUM_PINS-1:0] dout;
  logic                overrun;

  tdm_frame_serializer #(.NUM_PINS(NUM_PINS), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_tdm(cfg_tdm),
    .cfg_wide(cfg_wide), .conv_strobe(conv_strobe), .chan_data(chan_data),
    .bclk(bclk), .fsync(fsync), .dout(dout), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int r2_bad = 0;
  logic b_hist = 1'b0;
  logic [NUM_PINS-1:0] dout_hist = '0;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc       <= cyc + 1;
    b_hist    <= bclk;
    dout_hist <= dout;
    if (rst_n && (dout !== dout_hist) && !(b_hist && !bclk)) r2_bad <= r2_bad + 1;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [319:0] act, input logic [319:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [39:0] word_of(input logic [7:0] seed, input int ch);
    logic [31:0] h;
    h = ({24'h0, seed} * 32'h9E3779B1) ^ (32'(ch + 1) * 32'h85EBCA6B);
    return {seed, 8'(ch) ^ h[31:24], h[23:0]};
  endfunction

  function automatic logic [DATA_W-1:0] build(input logic [7:0] seed);
    logic [DATA_W-1:0] d;
    for (int ch = 0; ch < NUM_CH; ch++) d[ch*40 +: 40] = word_of(seed, ch);
    return d;
  endfunction

  function automatic logic [319:0] expected(input logic [7:0] seed, input int p,
                                            input int t, input int w);
    logic [319:0] e = '0;
    logic [39:0]  wd;
    for (int s = 0; s < t; s++) begin
      wd = word_of(seed, p*t + s);
      for (int b = w - 1; b >= 0; b--) e = {e[318:0], wd[b]};
    end
    return e;
  endfunction

  logic [319:0] cap [NUM_PINS];
  int period, t_sync, extra_fs, t_strobe;
  int change_at = -1;

  task automatic wait_rise();
    do @(negedge clk); while (!(bclk && !b_hist));
  endtask

  task automatic fire(input logic [7:0] seed);
    @(negedge clk);
    chan_data   = build(seed);
    conv_strobe = 1'b1;
    t_strobe    = cyc;
    @(negedge clk);
    conv_strobe = 1'b0;
  endtask

  task automatic grab(input int t, input int w);
    do wait_rise(); while (!fsync);
    t_sync   = cyc;
    extra_fs = 0;
    period   = 0;
    for (int p = 0; p < NUM_PINS; p++) cap[p] = 320'(dout[p]);
    for (int i = 1; i < t*w; i++) begin
      if (i == change_at) begin
        cfg_wide = 1'b1;
        cfg_tdm  = 2'd2;
        cfg_div  = 4'd2;
      end
      wait_rise();
      if (i == 1) period = cyc - t_sync;
      if (fsync) extra_fs++;
      for (int p = 0; p < NUM_PINS; p++) cap[p] = {cap[p][318:0], dout[p]};
    end
  endtask

  task automatic judge(input logic [7:0] seed, input int t, input int w,
                       input int d, input string tag);
    for (int p = 0; p < NUM_PINS; p++)
      check(cap[p] == expected(seed, p, t, w), "R4", tag, cap[p], expected(seed, p, t, w));
    check(extra_fs == 0, "R3", "fsync wider than one bit", 320'(extra_fs), 320'(0));
    check(period == 2*d, "R1", "bit period", 320'(period), 320'(2*d));
    wait_rise();
    check(dout == '0 && fsync == 1'b0, "R5,R6", "line after last bit",
          320'({fsync, dout}), 320'(0));
  endtask

  initial begin
    rst_n = 1'b0; cfg_div = 4'd1; cfg_tdm = 2'd0; cfg_wide = 1'b0;
    conv_strobe = 1'b0; chan_data = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(bclk == 0 && fsync == 0 && dout == '0 && overrun == 0, "R11", "reset outputs",
          320'({bclk, fsync, dout, overrun}), 320'(0));
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R7: no frame without a strobe
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        wait_rise();
        if (fsync || dout != '0) seen++;
      end
      check(seen == 0, "R7", "activity without strobe", 320'(seen), 320'(0));
    end

    // table of vectors
    foreach (VECS[v]) begin
      int t, w, d;
      t = 1 << VECS[v].tdm;
      w = VECS[v].wide ? 40 : 24;
      d = (VECS[v].div == 0) ? 1 : int'(VECS[v].div);
      cfg_div = VECS[v].div; cfg_tdm = VECS[v].tdm; cfg_wide = VECS[v].wide;
      repeat (40) @(negedge clk);
      fire(VECS[v].seed);
      grab(t, w);
      check((t_sync - t_strobe) >= d + 1 && (t_sync - t_strobe) <= 3*d + 3, "R7",
            "strobe to frame-sync latency", 320'(t_sync - t_strobe), 320'(2*d));
      judge(VECS[v].seed, t, w, d, "table frame");
    end

    // R10: config change mid-frame
    cfg_div = 4'd1; cfg_tdm = 2'd0; cfg_wide = 1'b0;
    repeat (40) @(negedge clk);
    fire(8'h5A);
    change_at = 8;
    grab(1, 24);
    change_at = -1;
    judge(8'h5A, 1, 24, 1, "R10 frame kept old config");
    repeat (40) @(negedge clk);
    fire(8'h77);
    grab(4, 40);
    judge(8'h77, 4, 40, 2, "R10 next frame uses new config");

    // R8 / R9 overrun
    cfg_div = 4'd1; cfg_tdm = 2'd1; cfg_wide = 1'b0;
    repeat (40) @(negedge clk);
    check(overrun == 1'b0, "R8", "flag before overrun", 320'(overrun), 320'(0));
    fire(8'hA1);
    do wait_rise(); while (!fsync);
    repeat (6) wait_rise();
    check(overrun == 1'b0, "R8", "flag during clean frame", 320'(overrun), 320'(0));
    fire(8'hB2);
    check(overrun == 1'b1, "R8", "flag after early strobe", 320'(overrun), 320'(1));
    grab(2, 24);
    judge(8'hB2, 2, 24, 1, "R9 replacement frame");
    repeat (20) @(negedge clk);
    fire(8'hC3);
    grab(2, 24);
    judge(8'hC3, 2, 24, 1, "frame after overrun");
    check(overrun == 1'b1, "R8", "flag stays set", 320'(overrun), 320'(1));

    // R2 edge discipline over whole run
    check(r2_bad == 0, "R2", "dout changes off falling edge", 320'(r2_bad), 320'(0));

    // R11 reset clears overrun
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(bclk == 0 && fsync == 0 && dout == '0 && overrun == 0, "R11",
          "outputs during reset", 320'({bclk, fsync, dout, overrun}), 320'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule